// File: doc/BRIEF.md
# Direct-Mapped Instruction Translation Buffer

This block translates instruction-fetch page numbers for a 32-bit core that uses 8 KB pages. It holds 64 entries, one per value of the low six bits of the virtual page number. The fetch side presents a page number with an enable. On the next clock edge the block registers the results: a hit flag, the physical page number, the user and supervisor execute permissions and a cache-inhibit flag. Exception generation, page-crossing detection and address muxing toward memory belong to the logic around it.

Software fills the buffer through a special-purpose-register port. Each entry is split into two registers. A tag register holds the upper virtual tag and a valid flag. A mapping register holds the physical page number and the attribute bits. Writes land on the next clock edge. Reads are combinational and return each stored field in the bit position it was written from.

Top module: `itlb_fetch_xlate`

## Requirements
- R1: Reset clears every valid flag and the registered lookup outputs, so every lookup misses until software writes the entries.
- R2: A tag register stores write-data bits 31:19 as the tag and bit 0 as the valid flag. A read returns them at the same positions, with all other bits zero.
- R3: A mapping register stores bits 31:13 as the physical page number, bit 7 as user execute, bit 6 as supervisor execute and bit 1 as cache inhibit. A read returns them at the same positions, with all other bits zero.
- R4: The 16-bit register address selects tag register i at 0x1200+i and mapping register i at 0x1300+i, for i from 0 to 63. A write to any other address changes nothing, and a read from one returns zero.
- R5: Read data is zero while the register select is low.
- R6: A lookup indexes the entry with page-number bits 5:0 (address bits 18:13). It reports a hit only when that entry is valid and its tag equals page-number bits 18:6 (address bits 31:19).
- R7: The hit flag and the indexed entry's page number and attributes appear on the outputs one clock after the enable is sampled high.
- R8: While the enable is low, all lookup outputs hold their values.
- R9: A register write is visible to a read and to a lookup in the very next cycle.
- R10: A write to one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_en | input | 1 | Lookup enable |
| lk_vpn | input | 19 | Virtual page number (address bits 31:13) |
| lk_hit | output | 1 | Registered hit flag |
| lk_ppn | output | 19 | Registered physical page number |
| lk_ux | output | 1 | Registered user-execute permission |
| lk_sx | output | 1 | Registered supervisor-execute permission |
| lk_ci | output | 1 | Registered cache-inhibit flag |
| spr_sel | input | 1 | Register access select |
| spr_we | input | 1 | Register write strobe |
| spr_addr | input | 16 | Register address |
| spr_wdata | input | 32 | Register write data |
| spr_rdata | output | 32 | Register read data |

## Verification
The bench attacks addresses just outside both register windows, such as 0x1240, 0x1340, 0x12C0 and 0x1100. A decoder that compared too few address bits would alias these onto real entries, and a later sweep of all 128 registers would show the corruption. Lookups mix matching tags with mismatching tags on the same index. They also probe an entry whose tag matches but whose valid flag is clear, which catches a compare that drops the valid term or takes the tag from the wrong bits. A back-to-back write and lookup exposes any extra pipeline stage. A lookup held with the enable low, while the page number changes, exposes outputs that track their inputs instead of holding.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_TAG   = 2'd1,
        TGT_MAP   = 2'd2
    } spr_tgt_e;
endpackage

// File: rtl/itlb_spr_decode.sv
module itlb_spr_decode
    import itlb_pkg::*;
#(
    parameter int SPR_AW = 16,
    parameter int IDX_W = 6,
    parameter logic [SPR_AW-1:0] TAG_BASE = 16'h1200,
    parameter logic [SPR_AW-1:0] MAP_BASE = 16'h1300
) (
    input  logic              sel,
    input  logic [SPR_AW-1:0] addr,
    output spr_tgt_e          tgt,
    output logic [IDX_W-1:0]  idx
);
    localparam int WIN_W = SPR_AW - IDX_W;

    logic [WIN_W-1:0] window;

    assign window = addr[SPR_AW-1:IDX_W];
    assign idx    = addr[IDX_W-1:0];

    always_comb begin
        tgt = TGT_NONE;
        if (sel && window == TAG_BASE[SPR_AW-1:IDX_W]) begin
            tgt = TGT_TAG;
        end else if (sel && window == MAP_BASE[SPR_AW-1:IDX_W]) begin
            tgt = TGT_MAP;
        end
    end
endmodule

// File: rtl/itlb_entry_store.sv
module itlb_entry_store #(
    parameter int ENTRIES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 13,
    parameter int PPN_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tag,
    input  logic             wr_map,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag_val,
    input  logic             wr_vld_val,
    input  logic [PPN_W-1:0] wr_ppn_val,
    input  logic [2:0]       wr_attr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic [PPN_W-1:0] rd_ppn,
    output logic [2:0]       rd_attr,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    output logic             lk_vld,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [2:0]       lk_attr
);
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [2:0]         attr_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_tag) begin
            vld_q[wr_idx] <= wr_vld_val;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_tag) begin
            tag_q[wr_idx] <= wr_tag_val;
        end
        if (wr_map) begin
            ppn_q[wr_idx]  <= wr_ppn_val;
            attr_q[wr_idx] <= wr_attr_val;
        end
    end

    assign rd_tag  = tag_q[rd_idx];
    assign rd_vld  = vld_q[rd_idx];
    assign rd_ppn  = ppn_q[rd_idx];
    assign rd_attr = attr_q[rd_idx];

    assign lk_tag  = tag_q[lk_idx];
    assign lk_vld  = vld_q[lk_idx];
    assign lk_ppn  = ppn_q[lk_idx];
    assign lk_attr = attr_q[lk_idx];
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup #(
    parameter int VPN_W = 19,
    parameter int IDX_W = 6,
    parameter int PPN_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx,
    input  logic [VPN_W-IDX_W-1:0] ent_tag,
    input  logic             ent_vld,
    input  logic [PPN_W-1:0] ent_ppn,
    input  logic [2:0]       ent_attr,
    output logic             hit_q,
    output logic [PPN_W-1:0] ppn_q,
    output logic [2:0]       attr_q
);
    localparam int TAG_W = VPN_W - IDX_W;

    logic match;

    assign idx   = vpn[IDX_W-1:0];
    assign match = ent_vld && (ent_tag == vpn[VPN_W-1 -: TAG_W]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            ppn_q  <= '0;
            attr_q <= '0;
        end else if (en) begin
            hit_q  <= match;
            ppn_q  <= ent_ppn;
            attr_q <= ent_attr;
        end
    end
endmodule

// File: rtl/itlb_fetch_xlate.sv
module itlb_fetch_xlate
    import itlb_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PAGE_SH = 13,
    parameter int ENTRIES = 64,
    parameter int SPR_AW = 16,
    parameter logic [SPR_AW-1:0] TAG_BASE = 16'h1200,
    parameter logic [SPR_AW-1:0] MAP_BASE = 16'h1300,
    parameter int UX_BIT = 7,
    parameter int SX_BIT = 6,
    parameter int CI_BIT = 1,
    parameter int VLD_BIT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_en,
    input  logic [VA_W-PAGE_SH-1:0]  lk_vpn,
    output logic                     lk_hit,
    output logic [VA_W-PAGE_SH-1:0]  lk_ppn,
    output logic                     lk_ux,
    output logic                     lk_sx,
    output logic                     lk_ci,
    input  logic                     spr_sel,
    input  logic                     spr_we,
    input  logic [SPR_AW-1:0]        spr_addr,
    input  logic [VA_W-1:0]          spr_wdata,
    output logic [VA_W-1:0]          spr_rdata
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int VPN_W = VA_W - PAGE_SH;
    localparam int PPN_W = VPN_W;
    localparam int TAG_W = VPN_W - IDX_W;

    spr_tgt_e         tgt;
    logic [IDX_W-1:0] spr_idx;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] rd_tag, ent_tag;
    logic             rd_vld, ent_vld;
    logic [PPN_W-1:0] rd_ppn, ent_ppn;
    logic [2:0]       rd_attr, ent_attr, attr_q;
    logic [2:0]       wr_attr;

    itlb_spr_decode #(
        .SPR_AW(SPR_AW), .IDX_W(IDX_W),
        .TAG_BASE(TAG_BASE), .MAP_BASE(MAP_BASE)
    ) u_dec (
        .sel(spr_sel), .addr(spr_addr), .tgt(tgt), .idx(spr_idx)
    );

    assign wr_attr = {spr_wdata[UX_BIT], spr_wdata[SX_BIT], spr_wdata[CI_BIT]};

    itlb_entry_store #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_tag(spr_we && tgt == TGT_TAG),
        .wr_map(spr_we && tgt == TGT_MAP),
        .wr_idx(spr_idx),
        .wr_tag_val(spr_wdata[VA_W-1 -: TAG_W]),
        .wr_vld_val(spr_wdata[VLD_BIT]),
        .wr_ppn_val(spr_wdata[VA_W-1 -: PPN_W]),
        .wr_attr_val(wr_attr),
        .rd_idx(spr_idx),
        .rd_tag(rd_tag), .rd_vld(rd_vld), .rd_ppn(rd_ppn), .rd_attr(rd_attr),
        .lk_idx(lk_idx),
        .lk_tag(ent_tag), .lk_vld(ent_vld), .lk_ppn(ent_ppn), .lk_attr(ent_attr)
    );

    itlb_lookup #(
        .VPN_W(VPN_W), .IDX_W(IDX_W), .PPN_W(PPN_W)
    ) u_lookup (
        .clk(clk), .rst_n(rst_n), .en(lk_en), .vpn(lk_vpn), .idx(lk_idx),
        .ent_tag(ent_tag), .ent_vld(ent_vld), .ent_ppn(ent_ppn), .ent_attr(ent_attr),
        .hit_q(lk_hit), .ppn_q(lk_ppn), .attr_q(attr_q)
    );

    assign lk_ux = attr_q[2];
    assign lk_sx = attr_q[1];
    assign lk_ci = attr_q[0];

    always_comb begin
        spr_rdata = '0;
        unique case (tgt)
            TGT_TAG: begin
                spr_rdata[VA_W-1 -: TAG_W] = rd_tag;
                spr_rdata[VLD_BIT]         = rd_vld;
            end
            TGT_MAP: begin
                spr_rdata[VA_W-1 -: PPN_W] = rd_ppn;
                spr_rdata[UX_BIT]          = rd_attr[2];
                spr_rdata[SX_BIT]          = rd_attr[1];
                spr_rdata[CI_BIT]          = rd_attr[0];
            end
            default: spr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/itlb_fetch_xlate_chk.sv
module itlb_fetch_xlate_chk #(
    parameter int VPN_W = 19,
    parameter int IDX_W = 6,
    parameter int ENTRIES = 64,
    parameter int SPR_AW = 16,
    parameter int DW = 32,
    parameter logic [SPR_AW-1:0] TAG_BASE = 16'h1200,
    parameter logic [SPR_AW-1:0] MAP_BASE = 16'h1300
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_en,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               lk_hit,
    input logic [VPN_W-1:0]   lk_ppn,
    input logic               lk_ux,
    input logic               lk_sx,
    input logic               lk_ci,
    input logic               spr_sel,
    input logic               spr_we,
    input logic [SPR_AW-1:0]  spr_addr,
    input logic [DW-1:0]      spr_wdata,
    input logic [DW-1:0]      spr_rdata,
    input logic [ENTRIES-1:0] vld
);
    logic in_tag_win, in_map_win;
    assign in_tag_win = spr_addr[SPR_AW-1:IDX_W] == TAG_BASE[SPR_AW-1:IDX_W];
    assign in_map_win = spr_addr[SPR_AW-1:IDX_W] == MAP_BASE[SPR_AW-1:IDX_W];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> ($stable(lk_hit) && $stable(lk_ppn) && $stable(lk_ux) && $stable(lk_sx) && $stable(lk_ci))); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !spr_sel |-> spr_rdata == '0); // R5

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_sel && !in_tag_win && !in_map_win) |-> spr_rdata == '0); // R4

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> (!lk_hit || $past(vld[lk_vpn[IDX_W-1:0]]))); // R6

    AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_sel && spr_we && in_tag_win) |=> vld[$past(spr_addr[IDX_W-1:0])] == $past(spr_wdata[0])); // R9

    AST_MAP_WRITE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_sel && spr_we && in_map_win) |=> $stable(vld)); // R10
endmodule

bind itlb_fetch_xlate itlb_fetch_xlate_chk #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES), .SPR_AW(SPR_AW), .DW(VA_W),
    .TAG_BASE(TAG_BASE), .MAP_BASE(MAP_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ux(lk_ux), .lk_sx(lk_sx), .lk_ci(lk_ci),
    .spr_sel(spr_sel), .spr_we(spr_we), .spr_addr(spr_addr),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .vld(u_store.vld_q)
);

// File: tb/sim_itlb_fetch_xlate.sv
module sim_itlb_fetch_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_en = 1'b0;
    logic [18:0] lk_vpn = '0;
    logic        lk_hit, lk_ux, lk_sx, lk_ci;
    logic [18:0] lk_ppn;
    logic        spr_sel = 1'b0;
    logic        spr_we = 1'b0;
    logic [15:0] spr_addr = '0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] spr_rdata;

    int checks = 0;
    int fails = 0;

    logic [12:0] m_tag [N];
    logic        m_vld [N];
    logic [18:0] m_ppn [N];
    logic        m_ux  [N];
    logic        m_sx  [N];
    logic        m_ci  [N];

    itlb_fetch_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ux(lk_ux), .lk_sx(lk_sx), .lk_ci(lk_ci),
        .spr_sel(spr_sel), .spr_we(spr_we), .spr_addr(spr_addr),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_tag_reg(int i);
        return {m_tag[i], 18'b0, m_vld[i]};
    endfunction

    function automatic logic [31:0] exp_map_reg(int i);
        return {m_ppn[i], 5'b0, m_ux[i], m_sx[i], 4'b0, m_ci[i], 1'b0};
    endfunction

    function automatic logic [22:0] exp_lookup(logic [18:0] vpn);
        int i = int'(vpn[5:0]);
        logic h = m_vld[i] && (m_tag[i] == vpn[18:6]);
        return {h, m_ppn[i], m_ux[i], m_sx[i], m_ci[i]};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic spr_wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        spr_sel = 1'b1; spr_we = 1'b1; spr_addr = a; spr_wdata = d;
        @(negedge clk);
        spr_sel = 1'b0; spr_we = 1'b0;
        if (a[15:6] == 10'h048) begin
            m_tag[a[5:0]] = d[31:19];
            m_vld[a[5:0]] = d[0];
        end else if (a[15:6] == 10'h04C) begin
            m_ppn[a[5:0]] = d[31:13];
            m_ux[a[5:0]] = d[7];
            m_sx[a[5:0]] = d[6];
            m_ci[a[5:0]] = d[1];
        end
    endtask

    task automatic spr_rd(string req, logic [15:0] a, logic [31:0] exp);
        spr_sel = 1'b1; spr_we = 1'b0; spr_addr = a;
        #1;
        check(req, {32'b0, spr_rdata}, {32'b0, exp});
        spr_sel = 1'b0;
    endtask

    task automatic lookup(string req, logic [18:0] vpn);
        @(negedge clk);
        lk_en = 1'b1; lk_vpn = vpn;
        @(negedge clk);
        lk_en = 1'b0;
        check(req, {41'b0, lk_hit, lk_ppn, lk_ux, lk_sx, lk_ci}, {41'b0, exp_lookup(vpn)});
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < N; i++) begin
            spr_rd(req, 16'h1200 + 16'(i), exp_tag_reg(i));
            spr_rd(req, 16'h1300 + 16'(i), exp_map_reg(i));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [22:0] held;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: outputs cleared and no valid entries after reset
        check("R1 outputs", {41'b0, lk_hit, lk_ppn, lk_ux, lk_sx, lk_ci}, 64'b0);
        for (int i = 0; i < N; i += 9) begin
            spr_rd("R1 valid cleared", 16'h1200 + 16'(i), {spr_rdata[31:1], 1'b0});
        end
        lookup("R1 miss", 19'h00000);
        check("R1 miss flag", {63'b0, lk_hit}, 64'b0);

        // R5: no select, read data zero
        spr_sel = 1'b0; spr_addr = 16'h1305; #1;
        check("R5 idle read", {32'b0, spr_rdata}, 64'b0);

        // R2 R3: load every entry
        for (int i = 0; i < N; i++) begin
            spr_wr(16'h1200 + 16'(i), $urandom());
            spr_wr(16'h1300 + 16'(i), $urandom());
        end
        sweep("R2 R3 readback");

        // R10: random overwrites, then full sweep shows only targets changed
        for (int k = 0; k < 150; k++) begin
            int i = int'($urandom_range(0, N - 1));
            spr_wr(($urandom_range(0, 1) == 0 ? 16'h1200 : 16'h1300) + 16'(i), $urandom());
        end
        sweep("R10 isolation");

        // R6 R7: random lookups, mostly with matching tags
        for (int k = 0; k < 300; k++) begin
            int i = int'($urandom_range(0, N - 1));
            logic [12:0] t = ($urandom_range(0, 3) != 0) ? m_tag[i] : 13'($urandom());
            lookup("R6 R7 lookup", {t, 6'(i)});
        end

        // R6: tag matches but valid clear must miss
        spr_wr(16'h1207, {13'h1ABC, 18'h3FFFF, 1'b0});
        lookup("R6 invalid entry", {13'h1ABC, 6'd7});
        // R6: same index, wrong tag must miss
        spr_wr(16'h1207, {13'h1ABC, 18'h0, 1'b1});
        lookup("R6 tag mismatch", {13'h1ABD, 6'd7});

        // R9: write then look up and read in the next cycle
        spr_wr(16'h1305, {19'h5A5A5, 5'h1F, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1});
        spr_rd("R9 map read next cycle", 16'h1305, exp_map_reg(5));
        spr_wr(16'h1205, {13'h0F0F, 18'h0, 1'b1});
        lookup("R9 lookup next cycle", {13'h0F0F, 6'd5});
        check("R9 hit", {63'b0, lk_hit}, 64'd1);

        // R8: hold while enable low
        held = {lk_hit, lk_ppn, lk_ux, lk_sx, lk_ci};
        @(negedge clk);
        lk_vpn = {13'h1111, 6'd7};
        repeat (3) @(negedge clk);
        check("R8 hold", {41'b0, lk_hit, lk_ppn, lk_ux, lk_sx, lk_ci}, {41'b0, held});

        // R4: addresses outside the windows ignored and read zero
        spr_wr(16'h1240, 32'hFFFF_FFFF);
        spr_wr(16'h1340, 32'hFFFF_FFFF);
        spr_wr(16'h12C0, 32'hFFFF_FFFF);
        spr_wr(16'h1100, 32'hFFFF_FFFF);
        spr_rd("R4 unmapped read", 16'h1240, 32'h0);
        spr_rd("R4 unmapped read", 16'h1340, 32'h0);
        spr_rd("R4 unmapped read", 16'h12C0, 32'h0);
        spr_rd("R4 unmapped read", 16'h1100, 32'h0);
        sweep("R4 no aliasing");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule